// File: doc/BRIEF.md
# Character Display Host Bus Driver

This block is the host-side master for a character display module that has an 8-bit parallel bus with a single enable strobe. It takes command or data bytes from a valid/ready request port. It drives the register-select, read/write and enable lines, and it drives the data lines out whenever it writes. A parameter sets the bus to either the full eight data lines or only the upper four lines; in the narrow mode every byte is sent as two halves.

After the synchronous reset, the block first pulses the module's active-low reset line. It then waits out the power-up time and writes a fixed setup sequence of four commands. When the last command is done, it raises a one-cycle done pulse and starts to accept host requests. Before every byte it reads the busy flag on the top data line, and it goes on reading until the flag is clear.

All timing minimums are given in nanoseconds or microseconds. They are turned into clock counts, rounded up, from a clock-period parameter.

Top module: `chardisp_host_drv`

## Requirements
- R1: While `rst` is high and after it is released, `lcd_rst_n` stays low for more than ceil(RSTPULSE_NS/CLK_NS) cycles. During reset, `req_ready` and `lcd_e` are low.
- R2: The first rising edge of `lcd_e` comes at least ceil(PWRUP_US*1000/CLK_NS) cycles after `lcd_rst_n` rises.
- R3: After reset the block writes four commands with register-select 0, in this order: function set (0x38 in 8-bit mode, 0x28 in 4-bit mode), display on (0x0C), clear (0x01), entry mode (0x06). It then raises `init_done` for exactly one cycle. `req_ready` is never high before that pulse.
- R4: `req_valid` has no effect while `req_ready` is low. A request held during setup is never written.
- R5: Before each byte it writes, the block performs busy reads with `lcd_rs`=0 and `lcd_rw`=1 and samples `db7_in` while `lcd_e` is high. It repeats the reads until the flag reads 0, and only then writes the byte.
- R6: With NIBBLE_BUS=0, each accepted byte appears whole on `db_out[7:0]` in one strobe, with `lcd_rs` equal to `req_is_data` and `lcd_rw`=0.
- R7: With NIBBLE_BUS=1, the high half goes on `db_out[7:4]` in one strobe and the low half on the same lines in the next strobe. No busy read comes between the two. `db_out[3:0]` is 0 during writes. A busy read uses two strobes, and the flag is taken from the first.
- R8: `lcd_rs` and `lcd_rw` are stable for at least ceil(SETUP_NS/CLK_NS) cycles before `lcd_e` rises. They stay stable while `lcd_e` is high and for at least ceil(HOLD_NS/CLK_NS) cycles after it falls.
- R9: Successive rising edges of `lcd_e` are at least ceil(ECYCLE_NS/CLK_NS) cycles apart.
- R10: `db_oe` is high during write strobes and low whenever `lcd_rw` is 1.
- R11: `req_ready` is high only while no transfer is in progress. While it is high, `lcd_e` and `db_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_is_data | input | 1 | 1 = data byte, 0 = command byte |
| req_byte | input | 8 | Byte to write |
| init_done | output | 1 | One-cycle pulse when setup finishes |
| lcd_rst_n | output | 1 | Active-low reset to the display module |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_e | output | 1 | Enable strobe |
| db_out | output | 8 | Data lines driven by the host |
| db_oe | output | 1 | Host drives the data lines |
| db7_in | input | 1 | Top data line as read back (busy flag) |

## Verification
The bench builds two copies of the block. One runs in 8-bit mode at CLK_NS=10, which gives multi-cycle setup, high and low phases. The other runs in 4-bit mode at CLK_NS=25, where the setup and hold minimums both round up to a single cycle and the low phase is set by the cycle minimum. A bus model plays the display: it holds the busy flag set for random spans and sometimes for 200 cycles, which forces repeated busy reads. It also records every write and reports any read that falls between two halves.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    typedef enum logic [2:0] {
        ST_RST_LO,
        ST_PWR_WAIT,
        ST_POLL,
        ST_WRITE,
        ST_IDLE
    } drv_state_e;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_HIGH,
        PH_LOW
    } strobe_ph_e;

    typedef struct packed {
        logic       is_data;
        logic [7:0] value;
    } xfer_t;

    localparam int INIT_LEN = 4;

    // time to cycles, rounded up, never below one cycle
    function automatic int cyc_ceil(input int t, input int clk_ns);
        int c;
        c = (t + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic [7:0] init_cmd(input int idx, input bit narrow);
        case (idx)
            0:       return narrow ? 8'h28 : 8'h38;
            1:       return 8'h0C;
            2:       return 8'h01;
            default: return 8'h06;
        endcase
    endfunction

endpackage

// File: rtl/chardisp_timer.sv
module chardisp_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/chardisp_strobe.sv
module chardisp_strobe
    import chardisp_pkg::*;
#(
    parameter int SU_CYC  = 2,
    parameter int HI_CYC  = 23,
    parameter int LO_CYC  = 25,
    parameter int STROBES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic e,
    output logic sample,
    output logic nib,
    output logic done
);
    localparam int CMAX01 = (SU_CYC > HI_CYC) ? SU_CYC : HI_CYC;
    localparam int CMAX   = (CMAX01 > LO_CYC) ? CMAX01 : LO_CYC;
    localparam int CW     = $clog2(CMAX + 1);
    localparam logic LAST_NIB = (STROBES > 1);

    strobe_ph_e    ph;
    logic [CW-1:0] cnt;
    logic          cnt_end;

    assign cnt_end = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= PH_SETUP;
            cnt    <= '0;
            nib    <= 1'b0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                ph     <= PH_SETUP;
                cnt    <= CW'(SU_CYC - 1);
                nib    <= 1'b0;
            end
        end else if (!cnt_end) begin
            cnt <= cnt - 1'b1;
        end else begin
            case (ph)
                PH_SETUP: begin
                    ph  <= PH_HIGH;
                    cnt <= CW'(HI_CYC - 1);
                end
                PH_HIGH: begin
                    ph  <= PH_LOW;
                    cnt <= CW'(LO_CYC - 1);
                end
                default: begin
                    if (nib == LAST_NIB) begin
                        active <= 1'b0;
                    end else begin
                        nib <= 1'b1;
                        ph  <= PH_SETUP;
                        cnt <= CW'(SU_CYC - 1);
                    end
                end
            endcase
        end
    end

    assign e      = active && (ph == PH_HIGH);
    assign sample = e && cnt_end && !nib;
    assign done   = active && (ph == PH_LOW) && cnt_end && (nib == LAST_NIB);
endmodule

// File: rtl/chardisp_host_drv.sv
module chardisp_host_drv
    import chardisp_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter bit NIBBLE_BUS  = 1'b0,
    parameter int SETUP_NS    = 20,
    parameter int HOLD_NS     = 10,
    parameter int EHIGH_NS    = 230,
    parameter int ECYCLE_NS   = 500,
    parameter int PWRUP_US    = 100,
    parameter int RSTPULSE_NS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_is_data,
    input  logic [7:0] req_byte,
    output logic       init_done,
    output logic       lcd_rst_n,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] db_out,
    output logic       db_oe,
    input  logic       db7_in
);
    localparam int SU_C   = cyc_ceil(SETUP_NS, CLK_NS);
    localparam int HI_C   = cyc_ceil(EHIGH_NS, CLK_NS);
    localparam int HOLD_C = cyc_ceil(HOLD_NS, CLK_NS);
    localparam int LO_RAW = cyc_ceil(ECYCLE_NS, CLK_NS) - SU_C - HI_C;
    localparam int LO_C   = (LO_RAW > HOLD_C) ? LO_RAW : HOLD_C;
    localparam int RST_C  = cyc_ceil(RSTPULSE_NS, CLK_NS) + 1;
    localparam int PWR_C  = cyc_ceil(PWRUP_US * 1000, CLK_NS);
    localparam int TMAX   = (PWR_C > RST_C) ? PWR_C : RST_C;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int IW     = $clog2(INIT_LEN);
    localparam int NSTB   = NIBBLE_BUS ? 2 : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(INIT_LEN - 1);

    drv_state_e    state;
    xfer_t         cur;
    logic [IW-1:0] init_idx;
    logic          in_init;
    logic          bf_q;

    logic tmr_zero, tmr_load;
    logic stb_start, stb_active, stb_e, stb_sample, stb_nib, stb_done;

    assign tmr_load = (state == ST_RST_LO) && tmr_zero;

    chardisp_timer #(
        .W       (TW),
        .RST_VAL (RST_C - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (TW'(PWR_C - 1)),
        .zero     (tmr_zero)
    );

    assign stb_start = ((state == ST_POLL) || (state == ST_WRITE)) && !stb_active;

    chardisp_strobe #(
        .SU_CYC  (SU_C),
        .HI_CYC  (HI_C),
        .LO_CYC  (LO_C),
        .STROBES (NSTB)
    ) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .start  (stb_start),
        .active (stb_active),
        .e      (stb_e),
        .sample (stb_sample),
        .nib    (stb_nib),
        .done   (stb_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RST_LO;
            cur       <= '0;
            init_idx  <= '0;
            in_init   <= 1'b1;
            bf_q      <= 1'b1;
            init_done <= 1'b0;
        end else begin
            init_done <= 1'b0;
            case (state)
                ST_RST_LO: begin
                    if (tmr_zero)
                        state <= ST_PWR_WAIT;
                end
                ST_PWR_WAIT: begin
                    if (tmr_zero) begin
                        state <= ST_POLL;
                        cur   <= '{is_data: 1'b0, value: init_cmd(0, NIBBLE_BUS)};
                    end
                end
                ST_POLL: begin
                    if (stb_sample)
                        bf_q <= db7_in;
                    if (stb_done && !bf_q)
                        state <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (stb_done) begin
                        bf_q <= 1'b1;
                        if (!in_init) begin
                            state <= ST_IDLE;
                        end else if (init_idx == LAST_IDX) begin
                            in_init   <= 1'b0;
                            init_done <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            init_idx <= init_idx + 1'b1;
                            cur      <= '{is_data: 1'b0,
                                          value: init_cmd(int'(init_idx) + 1, NIBBLE_BUS)};
                            state    <= ST_POLL;
                        end
                    end
                end
                default: begin
                    if (req_valid) begin
                        cur   <= '{is_data: req_is_data, value: req_byte};
                        state <= ST_POLL;
                    end
                end
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign lcd_rst_n = (state != ST_RST_LO);
    assign lcd_rs    = (state == ST_WRITE) && cur.is_data;
    assign lcd_rw    = (state == ST_POLL);
    assign lcd_e     = stb_e;
    assign db_oe     = (state == ST_WRITE);

    always_comb begin
        if (NIBBLE_BUS)
            db_out = {(stb_nib ? cur.value[3:0] : cur.value[7:4]), 4'h0};
        else
            db_out = cur.value;
    end
endmodule

// File: rtl/chardisp_host_drv_chk.sv
module chardisp_host_drv_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       init_done,
    input logic       lcd_rst_n,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic       db_oe
);
    logic done_seen;

    always_ff @(posedge clk) begin
        if (rst)
            done_seen <= 1'b0;
        else if (init_done)
            done_seen <= 1'b1;
    end

    p_e_after_rst_r2: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> lcd_rst_n);

    p_single_done_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> !init_done);

    p_ready_after_done_r3: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (done_seen || init_done));

    p_no_take_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !lcd_e) |=> !req_ready || init_done);

    p_ctl_stable_high_r8: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    p_ctl_setup_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    p_oe_write_only_r10: assert property (@(posedge clk) disable iff (rst)
        db_oe |-> !lcd_rw);

    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!lcd_e && !db_oe));
endmodule

bind chardisp_host_drv chardisp_host_drv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .init_done (init_done),
    .lcd_rst_n (lcd_rst_n),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_e     (lcd_e),
    .db_oe     (db_oe)
);

// File: tb/chardisp_host_drv_test.sv
module disp_model #(
    parameter bit NIB      = 1'b0,
    parameter int SU_MIN   = 2,
    parameter int HOLD_MIN = 1,
    parameter int CYC_MIN  = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_n,
    input  logic       rs,
    input  logic       rw,
    input  logic       e,
    input  logic [7:0] db_out,
    input  logic       db_oe,
    output logic       bf
);
    logic [8:0] log_q [0:63];
    int log_n, rst_low, first_rise_age, since_rst, busy;
    int v_setup, v_hold, v_cyc, v_nopoll, v_midpoll, v_lowlines, v_oe, poll_max, polls_cur;
    int ctl_age, fall_age, rise_age;
    bit have_rise, ready_seen, wr_half, rd_half, bf_lat, p_e, p_rstn;
    logic [1:0] p_ctl;
    logic [3:0] hi_nib;

    task automatic commit(input logic [7:0] b);
        if (log_n < 64) log_q[log_n] = {rs, b};
        log_n++;
        ready_seen = 0;
        if (polls_cur > poll_max) poll_max = polls_cur;
        polls_cur = 0;
        busy = (log_n % 4 == 0) ? 200 : int'($urandom_range(0, 40));
    endtask

    always @(negedge clk) begin
        if (rst) begin
            log_n = 0; rst_low = 0; first_rise_age = -1; since_rst = 0; busy = 0;
            v_setup = 0; v_hold = 0; v_cyc = 0; v_nopoll = 0; v_midpoll = 0;
            v_lowlines = 0; v_oe = 0; poll_max = 0; polls_cur = 0;
            ctl_age = 0; fall_age = 1000; rise_age = 0;
            have_rise = 0; ready_seen = 0; wr_half = 0; rd_half = 0; bf_lat = 0;
            p_e = 0; p_rstn = 0; p_ctl = 2'b00; hi_nib = 4'h0; bf = 1'b0;
        end else begin
            if (!rst_n) rst_low++;
            if (rst_n && !p_rstn) since_rst = 1; else since_rst++;
            if ({rs, rw} != p_ctl) begin
                if (fall_age < HOLD_MIN) v_hold++;
                ctl_age = 1;
            end else ctl_age++;
            if (e && !p_e) begin
                if (ctl_age - 1 < SU_MIN) v_setup++;
                if (have_rise && rise_age < CYC_MIN) v_cyc++;
                if (!have_rise) first_rise_age = since_rst;
                have_rise = 1;
                rise_age = 0;
                bf_lat = (busy != 0);
                bf = bf_lat;
            end
            rise_age++;
            if (e && (rw == db_oe)) v_oe++;
            if (!e && p_e) begin
                fall_age = 0;
                if (rw) begin
                    if (wr_half) v_midpoll++;
                    if (!rd_half) begin
                        polls_cur++;
                        if (!bf_lat) ready_seen = 1;
                    end
                    if (NIB) rd_half = !rd_half;
                end else if (NIB) begin
                    if (db_out[3:0] != 4'h0) v_lowlines++;
                    if (!wr_half) begin
                        if (!ready_seen) v_nopoll++;
                        hi_nib = db_out[7:4];
                        wr_half = 1;
                    end else begin
                        wr_half = 0;
                        commit({hi_nib, db_out[7:4]});
                    end
                end else begin
                    if (!ready_seen) v_nopoll++;
                    commit(db_out);
                end
            end
            if (!e) fall_age++;
            if (busy > 0) busy--;
            p_e = e; p_rstn = rst_n; p_ctl = {rs, rw};
        end
    end
endmodule

module chardisp_host_drv_test;
    localparam int CK_A = 10;
    localparam int CK_B = 25;

    function automatic int cmin(input int t, input int ck);
        int c;
        c = (t + ck - 1) / ck;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic [7:0] exp_init(input int i, input bit narrow);
        case (i)
            0: return narrow ? 8'h28 : 8'h38;
            1: return 8'h0C;
            2: return 8'h01;
            default: return 8'h06;
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic v_a = 1'b1, rs_a = 1'b1, v_b = 1'b1, rs_b = 1'b1;
    logic [7:0] d_a = 8'hAA, d_b = 8'hAA;
    logic rdy_a, done_a, rstn_a, lrs_a, lrw_a, e_a, oe_a, bf_a;
    logic rdy_b, done_b, rstn_b, lrs_b, lrw_b, e_b, oe_b, bf_b;
    logic [7:0] do_a, do_b;

    chardisp_host_drv #(.CLK_NS(CK_A), .NIBBLE_BUS(1'b0)) uut (
        .clk(clk), .rst(rst), .req_valid(v_a), .req_ready(rdy_a),
        .req_is_data(rs_a), .req_byte(d_a), .init_done(done_a),
        .lcd_rst_n(rstn_a), .lcd_rs(lrs_a), .lcd_rw(lrw_a), .lcd_e(e_a),
        .db_out(do_a), .db_oe(oe_a), .db7_in(bf_a));

    chardisp_host_drv #(.CLK_NS(CK_B), .NIBBLE_BUS(1'b1)) uut_n (
        .clk(clk), .rst(rst), .req_valid(v_b), .req_ready(rdy_b),
        .req_is_data(rs_b), .req_byte(d_b), .init_done(done_b),
        .lcd_rst_n(rstn_b), .lcd_rs(lrs_b), .lcd_rw(lrw_b), .lcd_e(e_b),
        .db_out(do_b), .db_oe(oe_b), .db7_in(bf_b));

    disp_model #(.NIB(1'b0), .SU_MIN(cmin(20, CK_A)), .HOLD_MIN(cmin(10, CK_A)),
                 .CYC_MIN(cmin(500, CK_A))) m_a (
        .clk(clk), .rst(rst), .rst_n(rstn_a), .rs(lrs_a), .rw(lrw_a), .e(e_a),
        .db_out(do_a), .db_oe(oe_a), .bf(bf_a));

    disp_model #(.NIB(1'b1), .SU_MIN(cmin(20, CK_B)), .HOLD_MIN(cmin(10, CK_B)),
                 .CYC_MIN(cmin(500, CK_B))) m_b (
        .clk(clk), .rst(rst), .rst_n(rstn_b), .rs(lrs_b), .rw(lrw_b), .e(e_b),
        .db_out(do_b), .db_oe(oe_b), .bf(bf_b));

    int checks = 0, failures = 0, wd = 0;
    int dcnt_a = 0, dcnt_b = 0, early_a = 0, early_b = 0, busyrdy_a = 0, busyrdy_b = 0;
    logic [8:0] exp_a [0:63];
    logic [8:0] exp_b [0:63];
    int ne_a = 0, ne_b = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (done_a) dcnt_a++;
            if (done_b) dcnt_b++;
            if (rdy_a && dcnt_a == 0 && !done_a) early_a++;
            if (rdy_b && dcnt_b == 0 && !done_b) early_b++;
            if (rdy_a && (e_a || oe_a)) busyrdy_a++;
            if (rdy_b && (e_b || oe_b)) busyrdy_b++;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(input bit which, input bit rs, input logic [7:0] b);
        if (!which) begin
            while (!rdy_a) @(negedge clk);
            v_a = 1'b1; rs_a = rs; d_a = b;
            @(negedge clk);
            v_a = 1'b0;
            exp_a[ne_a] = {rs, b}; ne_a++;
        end else begin
            while (!rdy_b) @(negedge clk);
            v_b = 1'b1; rs_b = rs; d_b = b;
            @(negedge clk);
            v_b = 1'b0;
            exp_b[ne_b] = {rs, b}; ne_b++;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rstn_a == 1'b0 && rstn_b == 1'b0, "R1 rst_n low in reset", int'(rstn_a), 0);
        chk(rdy_a == 1'b0 && rdy_b == 1'b0, "R1 ready low in reset", int'(rdy_a), 0);
        chk(e_a == 1'b0 && e_b == 1'b0, "R1 e low in reset", int'(e_a), 0);
        rst = 1'b0;
        // R4: valid held high during setup, dropped as soon as ready appears
        while (v_a || v_b) begin
            @(negedge clk);
            if (rdy_a) v_a = 1'b0;
            if (rdy_b) v_b = 1'b0;
        end
        repeat (5) @(negedge clk);
        chk(m_a.rst_low > cmin(500, CK_A), "R1 reset pulse width 8b", m_a.rst_low, cmin(500, CK_A) + 1);
        chk(m_b.rst_low > cmin(500, CK_B), "R1 reset pulse width 4b", m_b.rst_low, cmin(500, CK_B) + 1);
        chk(m_a.first_rise_age >= cmin(100000, CK_A), "R2 power-up wait 8b", m_a.first_rise_age, cmin(100000, CK_A));
        chk(m_b.first_rise_age >= cmin(100000, CK_B), "R2 power-up wait 4b", m_b.first_rise_age, cmin(100000, CK_B));
        chk(dcnt_a == 1 && dcnt_b == 1, "R3 single done pulse", dcnt_a * 10 + dcnt_b, 11);
        chk(early_a == 0 && early_b == 0, "R3 ready before done", early_a + early_b, 0);
        chk(m_a.log_n == 4, "R4 setup request ignored 8b", m_a.log_n, 4);
        chk(m_b.log_n == 4, "R4 setup request ignored 4b", m_b.log_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk(m_a.log_q[i] == {1'b0, exp_init(i, 1'b0)}, "R3 init cmd 8b", int'(m_a.log_q[i]), int'(exp_init(i, 1'b0)));
            chk(m_b.log_q[i] == {1'b0, exp_init(i, 1'b1)}, "R3 init cmd 4b", int'(m_b.log_q[i]), int'(exp_init(i, 1'b1)));
        end
        // directed corner bytes
        send(1'b0, 1'b1, 8'h00); send(1'b0, 1'b0, 8'hFF);
        send(1'b1, 1'b1, 8'hFF); send(1'b1, 1'b0, 8'h00);
        send(1'b1, 1'b1, 8'hA5); send(1'b0, 1'b1, 8'h5A);
        // random traffic
        for (int i = 0; i < 26; i++) begin
            send(1'b0, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
            send(1'b1, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
        end
        while (!(rdy_a && rdy_b && m_a.log_n == ne_a + 4 && m_b.log_n == ne_b + 4))
            @(negedge clk);
        for (int i = 0; i < ne_a; i++)
            chk(m_a.log_q[i + 4] == exp_a[i], "R6 8-bit byte", int'(m_a.log_q[i + 4]), int'(exp_a[i]));
        for (int i = 0; i < ne_b; i++)
            chk(m_b.log_q[i + 4] == exp_b[i], "R7 4-bit byte", int'(m_b.log_q[i + 4]), int'(exp_b[i]));
        chk(m_a.v_nopoll == 0 && m_b.v_nopoll == 0, "R5 write without clear busy read", m_a.v_nopoll + m_b.v_nopoll, 0);
        chk(m_a.poll_max >= 2, "R5 repeated busy read 8b", m_a.poll_max, 2);
        chk(m_b.poll_max >= 2, "R5 repeated busy read 4b", m_b.poll_max, 2);
        chk(m_b.v_midpoll == 0, "R7 read between halves", m_b.v_midpoll, 0);
        chk(m_b.v_lowlines == 0, "R7 low lines zero", m_b.v_lowlines, 0);
        chk(m_a.v_setup == 0 && m_b.v_setup == 0, "R8 setup", m_a.v_setup + m_b.v_setup, 0);
        chk(m_a.v_hold == 0 && m_b.v_hold == 0, "R8 hold", m_a.v_hold + m_b.v_hold, 0);
        chk(m_a.v_cyc == 0 && m_b.v_cyc == 0, "R9 e cycle", m_a.v_cyc + m_b.v_cyc, 0);
        chk(m_a.v_oe == 0 && m_b.v_oe == 0, "R10 drive enable", m_a.v_oe + m_b.v_oe, 0);
        chk(busyrdy_a == 0 && busyrdy_b == 0, "R11 ready while bus active", busyrdy_a + busyrdy_b, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule